// File: doc/BRIEF.md
# Message doorbell to edge interrupt frame

This block is a memory-mapped frame that turns message-signalled interrupt writes into single-cycle rising-edge pulses on a bank of shared peripheral interrupt lines. The frame owns a contiguous range of interrupt numbers, from `BASE_SPI` to `BASE_SPI + NUM_SPI - 1`. Output line `spi_pulse[i]` stands for interrupt number `BASE_SPI + i`. A simple 32-bit register port carries identification and type reads, and it also carries the doorbell writes that fire the lines.

The interrupt number behind a doorbell is decoded in one of three ways, chosen at compile time by `MODE`:
- Absolute: the write data is the number itself.
- Relative: the write data is an offset from a fixed bias. The bias is either the frame's base number or 32.
- Address-encoded: the number comes from the write address and the data is ignored. In this mode the frame spans 8 KiB instead of 4 KiB.

A configuration whose range leaves the legal interrupt window is flagged, and such a frame never fires. Doorbells that miss the owned range are dropped and leave a sticky error flag behind.

Top module: `msi_doorbell_frame`

## Requirements
- R1: After reset, `spi_pulse` is all zero, `drop_err` is 0 and `bus_rdata` is 0.
- R2: A read is sampled at a rising edge when `bus_rd` is 1. Its data is on `bus_rdata` during the following cycle, and `bus_rdata` is 0 in a cycle that follows no read. A read at byte offset 0x008 returns the type word: bits [25:16] hold `BASE_SPI`, bits [9:0] hold `NUM_SPI`, and all other bits are 0.
- R3: A read at offset 0xFCC returns `ID_VALUE`. A read at any other offset returns 0.
- R4: `cfg_bad` is 1 exactly when `BASE_SPI < 32` or `BASE_SPI + NUM_SPI > 1019`. A count of zero is rejected at elaboration. While `cfg_bad` is 1, no line ever pulses and every doorbell counts as dropped.
- R5: In absolute mode (`MODE` = 0), a write at offset 0x040 with data N, where N is in the owned range, raises `spi_pulse[N - BASE_SPI]` during the cycle after the write edge only.
- R6: In relative mode (`MODE` = 1), a write at offset 0x040 fires number data + bias. The bias is `BASE_SPI` when `OFFSET_FROM_BASE` = 1 and 32 when it is 0.
- R7: In address mode (`MODE` = 2), every write in the frame is a doorbell and its data is ignored. The fired number is 32 + `bus_addr[12:3]`.
- R8: A doorbell whose number falls outside the owned range produces no pulse and sets `drop_err`. `drop_err` then stays 1 until reset.
- R9: In absolute and relative modes, a write at any offset other than 0x040 fires nothing, leaves `drop_err` alone and does not change what the type and identification reads return.
- R10: At most one line pulses in any cycle, and no line pulses in a cycle that does not follow an accepted write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, accepted at every rising edge where it is 1 |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset within the frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, one cycle after the read |
| spi_pulse | output | NUM_SPI | One-cycle interrupt pulses; bit i is number BASE_SPI+i |
| cfg_bad | output | 1 | Configured range lies outside the legal window |
| drop_err | output | 1 | Sticky flag: a doorbell was dropped |

## Verification
Both a pulse and read data come from one register stage. A write or read that is sampled at edge k therefore shows its result during the cycle that edge k starts. The bench drives at falling edges, drops the strobe at the next falling edge and compares the outputs there. It then checks, at the following falling edge, that every line has returned to zero after the idle cycle. Five frames with different modes, bias choices and one invalid range all see the same bus traffic, and each is compared with a bench model of the decoding rules.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

   typedef enum logic [1:0] {
      DEC_ABS  = 2'd0,
      DEC_REL  = 2'd1,
      DEC_ADDR = 2'd2
   } dec_mode_e;

   localparam int unsigned OFF_TYPE  = 32'h008;
   localparam int unsigned OFF_DOOR  = 32'h040;
   localparam int unsigned OFF_IDENT = 32'hFCC;

   localparam int unsigned SPI_LOW_LIMIT  = 32;
   localparam int unsigned SPI_HIGH_LIMIT = 1019;
   localparam int unsigned NUM_W          = 33;

endpackage

// File: rtl/msi_num_resolve.sv
module msi_num_resolve
   import msi_frame_pkg::*;
#(
   parameter dec_mode_e   MODE       = DEC_ABS,
   parameter int unsigned REL_OFFSET = 32,
   parameter int unsigned ADDR_W     = 13
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic              door,
   output logic [NUM_W-1:0]  num
);

   generate
      if (MODE == DEC_ADDR) begin : g_addr
         logic unused_addr_mode;
         assign unused_addr_mode = ^{wdata, addr[2:0]};
         assign door = wr;
         assign num  = NUM_W'(SPI_LOW_LIMIT) + NUM_W'(addr[ADDR_W-1:3]);
      end else if (MODE == DEC_REL) begin : g_rel
         assign door = wr && (addr == ADDR_W'(OFF_DOOR));
         assign num  = NUM_W'(wdata) + NUM_W'(REL_OFFSET);
      end else begin : g_abs
         assign door = wr && (addr == ADDR_W'(OFF_DOOR));
         assign num  = NUM_W'(wdata);
      end
   endgenerate

endmodule

// File: rtl/msi_pulse_bank.sv
module msi_pulse_bank
   import msi_frame_pkg::*;
#(
   parameter int unsigned BASE_SPI = 64,
   parameter int unsigned NUM_SPI  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               door,
   input  logic [NUM_W-1:0]   num,
   input  logic               cfg_ok,
   output logic [NUM_SPI-1:0] pulse,
   output logic               err
);

   logic [NUM_W-1:0] rel;
   logic             in_range;
   logic             hit;

   assign rel      = num - NUM_W'(BASE_SPI);
   assign in_range = (num >= NUM_W'(BASE_SPI)) && (rel < NUM_W'(NUM_SPI));
   assign hit      = door && cfg_ok && in_range;

   generate
      for (genvar i = 0; i < NUM_SPI; i++) begin : g_line
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse[i] <= 1'b0;
            else        pulse[i] <= hit && (rel == NUM_W'(i));
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             err <= 1'b0;
      else if (door && !hit)  err <= 1'b1;
   end

endmodule

// File: rtl/msi_reg_read.sv
module msi_reg_read
   import msi_frame_pkg::*;
#(
   parameter int unsigned BASE_SPI = 64,
   parameter int unsigned NUM_SPI  = 32,
   parameter logic [31:0] ID_VALUE = 32'h0A1B_0042,
   parameter int unsigned ADDR_W   = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   output logic [31:0]       rdata
);

   localparam logic [9:0]  BASE_F    = 10'(BASE_SPI);
   localparam logic [9:0]  NUM_F     = 10'(NUM_SPI);
   localparam logic [31:0] TYPE_WORD = {6'b0, BASE_F, 6'b0, NUM_F};

   logic [31:0] mux;

   always_comb begin
      mux = 32'd0;
      if (addr == ADDR_W'(OFF_TYPE))       mux = TYPE_WORD;
      else if (addr == ADDR_W'(OFF_IDENT)) mux = ID_VALUE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= 32'd0;
      else        rdata <= rd ? mux : 32'd0;
   end

endmodule

// File: rtl/msi_doorbell_frame.sv
module msi_doorbell_frame
   import msi_frame_pkg::*;
#(
   parameter int unsigned BASE_SPI         = 64,
   parameter int unsigned NUM_SPI          = 32,
   parameter dec_mode_e   MODE             = DEC_ABS,
   parameter bit          OFFSET_FROM_BASE = 1'b1,
   parameter logic [31:0] ID_VALUE         = 32'h0A1B_0042,
   parameter int unsigned ADDR_W           = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic [NUM_SPI-1:0] spi_pulse,
   output logic               cfg_bad,
   output logic               drop_err
);

   localparam int unsigned REL_OFFSET = OFFSET_FROM_BASE ? BASE_SPI : SPI_LOW_LIMIT;
   localparam bit          CFG_BAD    = (BASE_SPI < SPI_LOW_LIMIT) ||
                                        (BASE_SPI + NUM_SPI > SPI_HIGH_LIMIT);

   generate
      if (NUM_SPI < 1) begin : g_chk_num
         $error("NUM_SPI must be at least 1");
      end
      if (BASE_SPI > 1023 || NUM_SPI > 1023) begin : g_chk_field
         $error("BASE_SPI and NUM_SPI must fit 10-bit type fields");
      end
      if (ADDR_W < 13) begin : g_chk_addr
         $error("ADDR_W must cover an 8 KiB frame");
      end
   endgenerate

   logic               door;
   logic [NUM_W-1:0]   num;

   assign cfg_bad = CFG_BAD;

   msi_num_resolve #(
      .MODE       (MODE),
      .REL_OFFSET (REL_OFFSET),
      .ADDR_W     (ADDR_W)
   ) u_resolve (
      .wr    (bus_wr),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .door  (door),
      .num   (num)
   );

   msi_pulse_bank #(
      .BASE_SPI (BASE_SPI),
      .NUM_SPI  (NUM_SPI)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .door   (door),
      .num    (num),
      .cfg_ok (!CFG_BAD),
      .pulse  (spi_pulse),
      .err    (drop_err)
   );

   msi_reg_read #(
      .BASE_SPI (BASE_SPI),
      .NUM_SPI  (NUM_SPI),
      .ID_VALUE (ID_VALUE),
      .ADDR_W   (ADDR_W)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .rd    (bus_rd),
      .addr  (bus_addr),
      .rdata (bus_rdata)
   );

endmodule

// File: rtl/msi_frame_chk.sv
module msi_frame_chk
   import msi_frame_pkg::*;
#(
   parameter int unsigned NUM_SPI = 32,
   parameter int unsigned ADDR_W  = 13
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic               bus_rd,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [31:0]        bus_rdata,
   input logic [NUM_SPI-1:0] spi_pulse,
   input logic               cfg_bad,
   input logic               drop_err
);

   a_r10_one_line: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(spi_pulse));

   a_r10_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> (spi_pulse == '0));

   a_r8_sticky_drop: assert property (@(posedge clk) disable iff (!rst_n)
      drop_err |=> drop_err);

   a_r4_bad_silent: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_bad |-> (spi_pulse == '0));

   a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr != ADDR_W'(OFF_TYPE)) && (bus_addr != ADDR_W'(OFF_IDENT)))
      |=> (bus_rdata == 32'd0));

   a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == 32'd0));

endmodule

bind msi_doorbell_frame msi_frame_chk #(
   .NUM_SPI (NUM_SPI),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .spi_pulse (spi_pulse),
   .cfg_bad   (cfg_bad),
   .drop_err  (drop_err)
);

// File: tb/msi_doorbell_frame_test.sv
module msi_doorbell_frame_test;
   import msi_frame_pkg::*;

   localparam int CLK_NS = 10;
   localparam logic [31:0] IDV = 32'h0A1B_0042;
   localparam int NI = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [12:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;

   logic [31:0] p_abs, p_rel, p_r32, p_bad;
   logic [63:0] p_adr;
   logic [31:0] rd_v [NI];
   logic        er_v [NI];
   logic        cb_v [NI];
   logic [63:0] act_p [NI];

   int n_checks = 0;
   int n_errors = 0;
   bit done = 0;

   // per-instance model configuration: mode, bias, base, count
   int m_mode [NI] = '{0, 1, 1, 2, 0};
   int m_offs [NI] = '{0, 64, 32, 0, 0};
   int m_base [NI] = '{64, 64, 64, 32, 1000};
   int m_num  [NI] = '{32, 32, 32, 64, 32};
   bit m_err  [NI] = '{0, 0, 0, 0, 0};

   always #(CLK_NS/2) clk = ~clk;

   msi_doorbell_frame #(.BASE_SPI(64), .NUM_SPI(32), .MODE(DEC_ABS), .ID_VALUE(IDV)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rd_v[0]), .spi_pulse(p_abs), .cfg_bad(cb_v[0]),
      .drop_err(er_v[0]));
   msi_doorbell_frame #(.BASE_SPI(64), .NUM_SPI(32), .MODE(DEC_REL), .OFFSET_FROM_BASE(1'b1),
                        .ID_VALUE(IDV)) u_rel (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rd_v[1]), .spi_pulse(p_rel), .cfg_bad(cb_v[1]),
      .drop_err(er_v[1]));
   msi_doorbell_frame #(.BASE_SPI(64), .NUM_SPI(32), .MODE(DEC_REL), .OFFSET_FROM_BASE(1'b0),
                        .ID_VALUE(IDV)) u_r32 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rd_v[2]), .spi_pulse(p_r32), .cfg_bad(cb_v[2]),
      .drop_err(er_v[2]));
   msi_doorbell_frame #(.BASE_SPI(32), .NUM_SPI(64), .MODE(DEC_ADDR), .ID_VALUE(IDV)) u_adr (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rd_v[3]), .spi_pulse(p_adr), .cfg_bad(cb_v[3]),
      .drop_err(er_v[3]));
   msi_doorbell_frame #(.BASE_SPI(1000), .NUM_SPI(32), .MODE(DEC_ABS), .ID_VALUE(IDV)) u_bad (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rd_v[4]), .spi_pulse(p_bad), .cfg_bad(cb_v[4]),
      .drop_err(er_v[4]));

   assign act_p[0] = {32'd0, p_abs};
   assign act_p[1] = {32'd0, p_rel};
   assign act_p[2] = {32'd0, p_r32};
   assign act_p[3] = p_adr;
   assign act_p[4] = {32'd0, p_bad};

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic bit cfg_is_bad(int k);
      return (m_base[k] < 32) || (m_base[k] + m_num[k] > 1019);
   endfunction

   // -2: not a doorbell; -1: dropped doorbell; else line index
   function automatic int exp_idx(int k, logic [12:0] a, logic [31:0] d);
      longint n;
      if (m_mode[k] == 2) n = 32 + longint'(a[12:3]);
      else if (a != 13'h040) return -2;
      else n = longint'(d) + longint'(m_mode[k] == 1 ? m_offs[k] : 0);
      if (cfg_is_bad(k)) return -1;
      if (n >= m_base[k] && n < m_base[k] + m_num[k]) return int'(n - m_base[k]);
      return -1;
   endfunction

   function automatic logic [31:0] exp_rd(int k, logic [12:0] a);
      if (a == 13'h008) return (32'(m_base[k]) << 16) | 32'(m_num[k]);
      if (a == 13'hFCC) return IDV;
      return 32'd0;
   endfunction

   function automatic string tag_of(int k, int idx);
      if (idx == -2) return "R9";
      if (idx == -1) return (k == 4) ? "R4" : "R8";
      case (k)
         0: return "R5";
         1, 2: return "R6";
         3: return "R7";
         default: return "R4";
      endcase
   endfunction

   task automatic do_write(input logic [12:0] a, input logic [31:0] d);
      @(negedge clk);
      for (int k = 0; k < NI; k++) check("R10", "idle pulses", act_p[k], 64'd0);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      for (int k = 0; k < NI; k++) begin
         int idx;
         logic [63:0] e;
         idx = exp_idx(k, a, d);
         if (idx == -1) m_err[k] = 1'b1;
         e = (idx >= 0) ? (64'd1 << idx) : 64'd0;
         check(tag_of(k, idx), $sformatf("pulse inst%0d a=%h d=%h", k, a, d), act_p[k], e);
         check(idx == -1 ? "R8" : tag_of(k, idx), $sformatf("drop_err inst%0d", k),
               64'(er_v[k]), 64'(m_err[k]));
      end
   endtask

   task automatic do_read(input logic [12:0] a);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      for (int k = 0; k < NI; k++)
         check((a == 13'h008) ? "R2" : "R3", $sformatf("rdata inst%0d a=%h", k, a),
               64'(rd_v[k]), 64'(exp_rd(k, a)));
      @(negedge clk);
      for (int k = 0; k < NI; k++) check("R2", "rdata idle", 64'(rd_v[k]), 64'd0);
   endtask

   initial begin
      #(CLK_NS * 150000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int k = 0; k < NI; k++) begin
         check("R1", "reset pulses", act_p[k], 64'd0);
         check("R1", "reset drop_err", 64'(er_v[k]), 64'd0);
         check("R1", "reset rdata", 64'(rd_v[k]), 64'd0);
         check("R4", "cfg_bad", 64'(cb_v[k]), 64'(cfg_is_bad(k)));
      end

      // directed reads
      do_read(13'h008);
      do_read(13'hFCC);
      do_read(13'h000);
      do_read(13'h044);
      do_read(13'h1FCC);

      // directed doorbells: range edges, then out of range
      do_write(13'h040, 32'd64);
      do_write(13'h040, 32'd95);
      do_write(13'h040, 32'd0);
      do_write(13'h040, 32'd31);
      do_write(13'h000, 32'd70);
      do_write(13'h1F8, 32'hFFFF_FFFF);
      do_write(13'h008, 32'hDEAD_BEEF);
      do_write(13'hFCC, 32'h1234_5678);
      do_read(13'h008);
      do_read(13'hFCC);
      do_write(13'h040, 32'd96);
      do_write(13'h040, 32'd63);
      do_write(13'h200, 32'd64);
      do_write(13'h040, 32'd1000);

      // constrained random traffic
      for (int i = 0; i < 600; i++) begin
         int sel;
         logic [12:0] a;
         logic [31:0] d;
         sel = $urandom_range(0, 11);
         if (sel <= 5)       a = 13'h040;
         else if (sel == 6)  a = 13'h008;
         else if (sel == 7)  a = 13'hFCC;
         else if (sel == 8)  a = 13'({$urandom_range(0, 79), 3'b000});
         else                a = 13'($urandom);
         d = ($urandom_range(0, 9) == 0) ? $urandom : 32'($urandom_range(0, 140));
         if (sel == 11) do_read(a);
         else           do_write(a, d);
      end

      @(negedge clk);
      for (int k = 0; k < NI; k++) check("R10", "final idle", act_p[k], 64'd0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule